// File: doc/BRIEF.md
# Configurable Interrupt Trigger Capture

This block is the input stage of a 51-source interrupt controller. Each clock it samples a vector of already-synchronous interrupt lines and keeps, per source, the level seen at the previous sample. From the current level, the previous level and three per-source configuration bits, it maintains a pending vector. The three bits are level/edge selection, active polarity and a both-edges option. The pending vector feeds the controller's masking and routing logic, which sit outside this block.

A source in level mode has a pending bit that simply mirrors its line after the polarity is applied. A source in edge mode latches its pending bit when the selected transition appears. The bit then holds until software releases it through the clear-mask input, and that input only acts on edge-mode sources. The configuration vectors come in on ports and are registered inside the block. Out of reset the registered copies take the controller's default source setup. That default is set by parameters and is in force for the first sample after reset.

Top module: `irq_trigger_capture`

## Requirements
- R1: `pending` is a register. A change on `src_in`, `edge_clr` or the configuration ports is seen at the output only after the rising clock edge that samples it. The configuration ports take effect one clock after the data inputs, because they pass through a register stage first.
- R2: A source whose registered level bit is 1 is in level mode. Its pending bit becomes 1 when the sampled input equals its registered polarity bit, and 0 otherwise. Polarity bit 1 means active-high and 0 means active-low.
- R3: An edge-mode source (level bit 0) whose both-edges bit is 1 sets its pending bit whenever the sampled input differs from the stored previous level, whatever its polarity bit.
- R4: An edge-mode source whose both-edges bit is 0 sets its pending bit on a 0-to-1 step when its polarity bit is 1, and on a 1-to-0 step when its polarity bit is 0. A transition never clears the bit.
- R5: The stored previous level of every source takes the sampled input on every clock, whatever the source's mode. A source switched from level to edge mode while its line is steady therefore sees no edge.
- R6: An `edge_clr` bit of 1 clears the pending bit of an edge-mode source. It has no effect on a level-mode source.
- R7: When a qualifying edge and a clear hit the same source in the same cycle, the pending bit is 1 afterwards.
- R8: Reset is synchronous and active-high. It sets pending and previous levels to 0. It loads the registered configuration with the defaults: level = 0x1F07FFF8FFFF, both-edges = 0xF800070000, polarity = 0x5F07FFF8FFFF (bit n = source n).
- R9: An edge-mode pending bit with no qualifying edge and no clear keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Interrupt lines, already synchronous to clk |
| cfg_level | input | NUM_SRC | 1 = level mode, 0 = edge mode, per source |
| cfg_pol_hi | input | NUM_SRC | 1 = active-high / rising, 0 = active-low / falling |
| cfg_both | input | NUM_SRC | 1 = edge-mode source latches on either transition |
| edge_clr | input | NUM_SRC | 1 = release the latched bit of an edge-mode source |
| pending | output | NUM_SRC | Registered raw pending vector |

## Verification
The two functions that can meet in one cycle are edge capture and the software clear on the same edge-mode source. They can also meet as a clear aimed at a mixed set of level and edge sources. The bench provokes the first case by toggling a line in the cycle it raises the clear for that source, and the second by holding a full clear mask while level sources follow their inputs. A behavioural reference judges both cycle by cycle: a new edge must leave the bit set, and level bits must ignore the mask. A long random phase then lets both collisions arise freely across all modes.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;
  // Default source setup, bit n = source n (wide enough for up to 64 sources)
  localparam logic [63:0] DEF_LEVEL_64 = 64'h0000_1F07_FFF8_FFFF;
  localparam logic [63:0] DEF_BOTH_64  = 64'h0000_00F8_0007_0000;
  localparam logic [63:0] DEF_POL_64   = 64'h0000_5F07_FFF8_FFFF;

  typedef enum logic [1:0] {
    MODE_LEVEL  = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_BOTH   = 2'd2
  } trig_mode_e;
endpackage

// File: rtl/irqcap_cfg_stage.sv
module irqcap_cfg_stage #(
  parameter int NUM_SRC = 51,
  parameter logic [NUM_SRC-1:0] DEF_LEVEL = '0,
  parameter logic [NUM_SRC-1:0] DEF_BOTH  = '0,
  parameter logic [NUM_SRC-1:0] DEF_POL   = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] level_in,
  input  logic [NUM_SRC-1:0] pol_in,
  input  logic [NUM_SRC-1:0] both_in,
  output logic [NUM_SRC-1:0] level_q,
  output logic [NUM_SRC-1:0] pol_q,
  output logic [NUM_SRC-1:0] both_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= DEF_LEVEL;
      pol_q   <= DEF_POL;
      both_q  <= DEF_BOTH;
    end else begin
      level_q <= level_in;
      pol_q   <= pol_in;
      both_q  <= both_in;
    end
  end
endmodule

// File: rtl/irqcap_cell.sv
module irqcap_cell
  import irqcap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic is_level,
  input  logic pol_hi,
  input  logic both,
  input  logic clr,
  output logic pend_q,
  output logic last_q
);
  trig_mode_e mode;
  logic       active_lvl;
  logic       step_up;
  logic       step_down;
  logic       edge_hit;
  logic       pend_d;

  always_comb begin
    if (is_level)  mode = MODE_LEVEL;
    else if (both) mode = MODE_BOTH;
    else           mode = MODE_SINGLE;

    active_lvl = (line == pol_hi);
    step_up    = line & ~last_q;
    step_down  = ~line & last_q;

    unique case (mode)
      MODE_BOTH:   edge_hit = step_up | step_down;
      MODE_SINGLE: edge_hit = pol_hi ? step_up : step_down;
      default:     edge_hit = 1'b0;
    endcase

    // a fresh edge outranks a clear in the same cycle
    if (mode == MODE_LEVEL) pend_d = active_lvl;
    else                    pend_d = edge_hit | (pend_q & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      last_q <= line;
    end
  end
endmodule

// File: rtl/irq_trigger_capture.sv
module irq_trigger_capture #(
  parameter int NUM_SRC = 51,
  parameter logic [NUM_SRC-1:0] DEF_LEVEL = irqcap_pkg::DEF_LEVEL_64[NUM_SRC-1:0],
  parameter logic [NUM_SRC-1:0] DEF_BOTH  = irqcap_pkg::DEF_BOTH_64[NUM_SRC-1:0],
  parameter logic [NUM_SRC-1:0] DEF_POL   = irqcap_pkg::DEF_POL_64[NUM_SRC-1:0]
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] cfg_level,
  input  logic [NUM_SRC-1:0] cfg_pol_hi,
  input  logic [NUM_SRC-1:0] cfg_both,
  input  logic [NUM_SRC-1:0] edge_clr,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] lvl_q;
  logic [NUM_SRC-1:0] pol_q;
  logic [NUM_SRC-1:0] both_q;
  logic [NUM_SRC-1:0] prev_q;

  irqcap_cfg_stage #(
    .NUM_SRC  (NUM_SRC),
    .DEF_LEVEL(DEF_LEVEL),
    .DEF_BOTH (DEF_BOTH),
    .DEF_POL  (DEF_POL)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .level_in(cfg_level),
    .pol_in  (cfg_pol_hi),
    .both_in (cfg_both),
    .level_q (lvl_q),
    .pol_q   (pol_q),
    .both_q  (both_q)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irqcap_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .line    (src_in[g]),
      .is_level(lvl_q[g]),
      .pol_hi  (pol_q[g]),
      .both    (both_q[g]),
      .clr     (edge_clr[g]),
      .pend_q  (pending[g]),
      .last_q  (prev_q[g])
    );
  end
endmodule

// File: rtl/irq_trigger_capture_chk.sv
module irq_trigger_capture_chk #(
  parameter int NUM_SRC = 51
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] edge_clr,
  input logic [NUM_SRC-1:0] pending,
  input logic [NUM_SRC-1:0] prev_q,
  input logic [NUM_SRC-1:0] lvl_q,
  input logic [NUM_SRC-1:0] pol_q,
  input logic [NUM_SRC-1:0] both_q
);
  // R8: reset empties pending and previous levels
  assert_reset_clean_R8: assert property (@(posedge clk)
    rst |=> (pending == '0 && prev_q == '0));

  // R5: previous level tracks the input on every clock
  assert_prev_follows_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prev_q == $past(src_in)));

  // R2 and R6: level sources mirror the polarised input, clear has no say
  assert_level_mirror_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(lvl_q) & (pending ^ ~($past(src_in) ^ $past(pol_q)))) == '0));

  // R3 and R7: a both-edges transition always leaves the bit set
  assert_both_edge_sets_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(src_in) ^ $past(prev_q)) & $past(both_q) & ~$past(lvl_q)
              & ~pending) == '0));

  // R9: a latched edge bit survives while no clear is applied
  assert_edge_hold_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pending) & ~$past(lvl_q) & ~$past(edge_clr) & ~pending) == '0));

  // R6: a set level-mode bit is not dropped by a clear while its line stays active
  assert_clear_level_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(lvl_q) & $past(edge_clr) & ~($past(src_in) ^ $past(pol_q))
              & ~pending) == '0));
endmodule

bind irq_trigger_capture irq_trigger_capture_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_in  (src_in),
  .edge_clr(edge_clr),
  .pending (pending),
  .prev_q  (prev_q),
  .lvl_q   (lvl_q),
  .pol_q   (pol_q),
  .both_q  (both_q)
);

// File: tb/sim_irq_trigger_capture.sv
module sim_irq_trigger_capture;
  localparam int  N       = 51;
  localparam time CLK_PER = 10ns;
  localparam logic [N-1:0] D_LVL  = 51'h1F07FFF8FFFF;
  localparam logic [N-1:0] D_BOTH = 51'h00F800070000;
  localparam logic [N-1:0] D_POL  = 51'h5F07FFF8FFFF;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src = '0, lvl = '0, pol = '0, both = '0, clr = '0;
  logic [N-1:0] pending;

  int    n_chk  = 0;
  int    n_fail = 0;
  string tag    = "R8";

  // behavioural reference
  logic [N-1:0] m_pend, m_prev, m_lvl, m_pol, m_both;

  always #(CLK_PER/2) clk = ~clk;

  irq_trigger_capture #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst(rst), .src_in(src), .cfg_level(lvl), .cfg_pol_hi(pol),
    .cfg_both(both), .edge_clr(clr), .pending(pending)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_prev = '0;
      m_lvl = D_LVL; m_pol = D_POL; m_both = D_BOTH;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit hit;
        if (m_lvl[i]) begin
          m_pend[i] = (src[i] == m_pol[i]);
        end else begin
          if (m_both[i])      hit = (src[i] != m_prev[i]);
          else if (m_pol[i])  hit = (src[i] && !m_prev[i]);
          else                hit = (!src[i] && m_prev[i]);
          if (hit)            m_pend[i] = 1'b1;
          else if (clr[i])    m_pend[i] = 1'b0;
        end
      end
      m_prev = src;
      m_lvl = lvl; m_pol = pol; m_both = both;
    end
  end

  task automatic check_out();
    n_chk++;
    if (pending !== m_pend) begin
      n_fail++;
      $display("FAIL %s pending=%h expected=%h", tag, pending, m_pend);
    end
  endtask

  task automatic step(input logic [N-1:0] s, input logic [N-1:0] c);
    src = s; clr = c;
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic set_cfg(input logic [N-1:0] l, input logic [N-1:0] p,
                         input logic [N-1:0] b);
    lvl = l; pol = p; both = b;
    step(src, '0);   // let the registered configuration settle
  endtask

  localparam logic [N-1:0] ALT = {26{2'b01}};

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (pending !== '0) begin
      n_fail++;
      $display("FAIL R8 pending=%h expected=%h", pending, {N{1'b0}});
    end
    // R8: first sample after reset uses default setup, ports all zero
    rst = 1'b0;
    step('1, '0);
    tag = "R8";
    n_chk++;
    if (pending !== ((D_LVL & D_POL) | (~D_LVL & (D_POL | D_BOTH)))) begin
      n_fail++;
      $display("FAIL R8 pending=%h expected=%h", pending,
               (D_LVL & D_POL) | (~D_LVL & (D_POL | D_BOTH)));
    end
    // R1: configuration one clock late, output registered
    tag = "R1"; step('0, '1); step('0, '1);
    // R2: level mode, alternating polarity
    tag = "R2"; set_cfg('1, ALT, '0);
    step('0, '0); step('1, '0); step(ALT, '1); step(~ALT, '0);
    // R4 and R9: single edge
    tag = "R4"; set_cfg('0, ALT, '0);
    step('0, '1); step('1, '0); step('1, '0); step('0, '0); step('0, '0);
    tag = "R9"; step('0, '0); step('0, '0);
    // R6: clear releases edge sources only
    tag = "R6"; step('0, '1); set_cfg(ALT, '1, '0);
    step(~ALT, '0); step('1, '1); step('1, '1); step('0, '1);
    // R3: both edges
    tag = "R3"; set_cfg('0, '0, '1);
    step('0, '1); step(ALT, '0); step(ALT, '1); step('0, '0); step('1, '1);
    // R7: edge and clear in the same cycle
    tag = "R7"; step('1, '1); step('0, '1); step(ALT, '1); step(ALT, '1);
    // R5: leave level mode while line steady, no phantom edge
    tag = "R5"; set_cfg('1, '1, '0); step('1, '0); step('1, '0);
    lvl = '0; step('1, '1); step('1, '0); step('1, '0);
    // mixed random traffic: R2 R3 R4 R6 R7
    tag = "random R2 R3 R4 R6 R7";
    for (int k = 0; k < 4000; k++) begin
      if (k % 37 == 0) begin
        lvl  = {$urandom, $urandom};
        pol  = {$urandom, $urandom};
        both = {$urandom, $urandom};
      end
      step({$urandom, $urandom}, {$urandom, $urandom} & {$urandom, $urandom});
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule